// File: doc/BRIEF.md
# Multi-Stream Strided Block Prefetcher

This block sits beside a data cache and watches the stream of demand block addresses it is given, one per cycle at most. It keeps a small table of access streams. Each stream learns a constant block distance (the stride) from the demand addresses that fall near it. Once the same stride has been seen twice in a row, the stream is confirmed and starts issuing prefetch block addresses ahead of the demand stream, up to a fixed number of blocks beyond the newest demand access.

Prefetch requests leave through a single valid/ready port. At most one new request is chosen per cycle. Confirmed streams take turns in round-robin order. A request that has been presented waits, unchanged, until the consumer accepts it. A plain upper address bound stops a stream from running past the end of the prefetchable region, and that includes a stream that wraps below block zero.

Top module: `stride_prefetcher`

## Requirements
- R1: In the cycle after the synchronous active-high reset `rst`, `pf_valid` is low and the table holds no stream, so no prefetch can appear before three new demand accesses.
- R2: A demand access that matches no stream (not an expected next block, not a repeat, not within the window) starts a new stream in the lowest-numbered free entry. When all eight entries are in use, it takes the entry touched least recently, and the history of the evicted stream is lost.
- R3: Accesses to blocks b, b+N and b+2N confirm a stream. No prefetch is issued after only the first two of them, and the first prefetch of the stream is block b+3N.
- R4: The stride N may be any nonzero constant number of blocks, including negative values and values other than one. Block addresses are taken modulo 2^ADDR_W.
- R5: A confirmed stream keeps at most LOOKAHEAD (12) prefetches beyond its latest demand block. With no further demand it issues b+3N through b+14N in that order and then stops.
- R6: A demand access at the expected next block of a confirmed stream that is LOOKAHEAD ahead releases exactly one more prefetch: the block one stride past its furthest prefetch.
- R7: An access within the window of a stream, other than its expected next block or its last block, restarts that stream with the stride set to the new distance. One further access at that new stride confirms it again, and prefetching restarts one stride past that access. The order of matching is expected next block first, then a repeat of the last block, then the window, then a new stream; within each class the lowest entry index wins.
- R8: A repeat of a stream's last block changes neither that stream's position nor its stride, and it issues no prefetch.
- R9: At most one prefetch is loaded into the output per cycle. Eligible streams are served round-robin, starting with the entry after the one served last.
- R10: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_blk` stays unchanged. No request is dropped or issued twice.
- R11: No prefetch is issued for a block address at or above PF_LIMIT (default 0xF00000). A stream whose next block lies there, including one that wrapped below zero, issues nothing more.
- R12: An access more than NEAR_WIN (16) blocks away from the last block of every stream starts a new stream and does not retrain an existing one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dmd_valid | input | 1 | A demand access is present this cycle |
| dmd_blk | input | ADDR_W | Block address of the demand access |
| pf_ready | input | 1 | Consumer accepts the presented prefetch |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_blk | output | ADDR_W | Block address to prefetch |

## Verification
The bench drives the confirmation boundary: two accesses must leave the output quiet, and a design that confirms one access early would emit a prefetch there. Negative strides and a stream that runs into the address bound are both driven; a design with an unsigned distance or a missing bound check would issue blocks near the top of the address space. The lookahead ceiling is counted exactly, so an off-by-one in the outstanding counter shows up as 11 or 13 requests. With `pf_ready` held low and two streams waiting, a design that changes the presented address or skips the round-robin turn breaks the expected alternation. A full table then has its least recent stream evicted, and an LRU error would keep the old stride alive and let it prefetch.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Life cycle of one stream entry.
  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_ALLOC = 2'd1,
    ST_ONE   = 2'd2,
    ST_CONF  = 2'd3
  } strm_state_e;

  // What a demand access does to the table.
  typedef enum logic [2:0] {
    DK_NONE,
    DK_ADV,
    DK_TOUCH,
    DK_RESTRIDE,
    DK_ALLOC
  } dmd_kind_e;

endpackage

// File: rtl/pf_rr_arbiter.sv
module pf_rr_arbiter #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] grant,
  output logic         any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;

  // Search starts at the pointer and wraps around.
  always_comb begin
    grant = '0;
    win   = '0;
    any   = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!any && req[idx]) begin
        any        = 1'b1;
        win        = IW'(idx);
        grant[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv && any) begin
      ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
  end

endmodule

// File: rtl/pf_issue_slot.sv
module pf_issue_slot #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cand_valid,
  input  logic [AW-1:0] cand_blk,
  input  logic          out_ready,
  output logic          load,
  output logic          out_valid,
  output logic [AW-1:0] out_blk
);
  // The slot refills when it is empty or being emptied this cycle.
  assign load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_blk   <= '0;
    end else if (load) begin
      out_valid <= cand_valid;
      if (cand_valid) out_blk <= cand_blk;
    end
  end

endmodule

// File: rtl/pf_stream_table.sv
module pf_stream_table
  import pf_pkg::*;
#(
  parameter int          NUM   = 8,
  parameter int          AW    = 24,
  parameter int          LOOK  = 12,
  parameter int          WIN   = 16,
  parameter logic [AW-1:0] LIMIT = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dmd_valid,
  input  logic [AW-1:0]   dmd_blk,
  input  logic [NUM-1:0]  issue_vec,
  output logic [NUM-1:0]  elig_vec,
  output logic [NUM-1:0]  conf_vec,
  output logic [NUM*AW-1:0] next_flat
);
  localparam int IW = (NUM > 1) ? $clog2(NUM) : 1;
  localparam int CW = $clog2(LOOK + 1);
  localparam logic [CW-1:0] LOOK_C = CW'(LOOK);
  localparam logic [IW-1:0] OLDEST = IW'(NUM - 1);
  localparam logic signed [AW:0] WIN_P = (AW+1)'(WIN);
  localparam logic signed [AW:0] WIN_N = -WIN_P;

  // Signed distance between two block addresses.
  function automatic logic signed [AW:0] blk_dist(logic [AW-1:0] a, logic [AW-1:0] b);
    return $signed({1'b0, a}) - $signed({1'b0, b});
  endfunction

  function automatic logic in_window(logic signed [AW:0] d);
    return (d != '0) && (d <= WIN_P) && (d >= WIN_N);
  endfunction

  function automatic logic [IW-1:0] first_set(logic [NUM-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int k = NUM - 1; k >= 0; k--) if (v[k]) r = IW'(k);
    return r;
  endfunction

  strm_state_e   st_q   [NUM];
  strm_state_e   st_d   [NUM];
  logic [AW-1:0] last_q [NUM];
  logic [AW-1:0] last_d [NUM];
  logic [AW-1:0] strd_q [NUM];
  logic [AW-1:0] strd_d [NUM];
  logic [AW-1:0] next_q [NUM];
  logic [AW-1:0] next_d [NUM];
  logic [CW-1:0] ahd_q  [NUM];
  logic [CW-1:0] ahd_d  [NUM];
  logic [IW-1:0] age_q  [NUM];
  logic [IW-1:0] age_d  [NUM];

  logic [NUM-1:0] exp_hit, same_hit, near_hit, free_vec, old_vec;
  dmd_kind_e      kind;
  logic [IW-1:0]  tgt;

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    logic has_stride;
    assign has_stride  = (st_q[g] == ST_ONE) || (st_q[g] == ST_CONF);
    assign exp_hit[g]  = has_stride && ((last_q[g] + strd_q[g]) == dmd_blk);
    assign same_hit[g] = (st_q[g] != ST_FREE) && (last_q[g] == dmd_blk);
    assign near_hit[g] = (st_q[g] != ST_FREE) && in_window(blk_dist(dmd_blk, last_q[g]));
    assign free_vec[g] = (st_q[g] == ST_FREE);
    assign old_vec[g]  = (age_q[g] == OLDEST);
    assign conf_vec[g] = (st_q[g] == ST_CONF);
    assign elig_vec[g] = conf_vec[g] && (ahd_q[g] < LOOK_C) && (next_q[g] < LIMIT);
    assign next_flat[g*AW +: AW] = next_q[g];
  end

  // Classify the demand access by priority class.
  always_comb begin
    kind = DK_NONE;
    tgt  = '0;
    if (dmd_valid) begin
      if (|exp_hit) begin
        kind = DK_ADV;
        tgt  = first_set(exp_hit);
      end else if (|same_hit) begin
        kind = DK_TOUCH;
        tgt  = first_set(same_hit);
      end else if (|near_hit) begin
        kind = DK_RESTRIDE;
        tgt  = first_set(near_hit);
      end else begin
        kind = DK_ALLOC;
        tgt  = (|free_vec) ? first_set(free_vec) : first_set(old_vec);
      end
    end
  end

  // Issue updates first, demand updates on top of them.
  always_comb begin
    for (int i = 0; i < NUM; i++) begin
      st_d[i]   = st_q[i];
      last_d[i] = last_q[i];
      strd_d[i] = strd_q[i];
      next_d[i] = issue_vec[i] ? next_q[i] + strd_q[i] : next_q[i];
      ahd_d[i]  = ahd_q[i] + CW'(issue_vec[i]);
      age_d[i]  = age_q[i];
      if (kind != DK_NONE) begin
        if (IW'(i) == tgt)               age_d[i] = '0;
        else if (age_q[i] < age_q[tgt])  age_d[i] = age_q[i] + 1'b1;
      end
    end
    case (kind)
      DK_ADV: begin
        last_d[tgt] = dmd_blk;
        if (st_q[tgt] == ST_ONE) begin
          st_d[tgt]   = ST_CONF;
          next_d[tgt] = dmd_blk + strd_q[tgt];
          ahd_d[tgt]  = '0;
        end else if (ahd_d[tgt] != '0) begin
          ahd_d[tgt]  = ahd_d[tgt] - 1'b1;
        end else begin
          next_d[tgt] = dmd_blk + strd_q[tgt];
        end
      end
      DK_RESTRIDE: begin
        st_d[tgt]   = ST_ONE;
        strd_d[tgt] = AW'(blk_dist(dmd_blk, last_q[tgt]));
        last_d[tgt] = dmd_blk;
        next_d[tgt] = dmd_blk;
        ahd_d[tgt]  = '0;
      end
      DK_ALLOC: begin
        st_d[tgt]   = ST_ALLOC;
        strd_d[tgt] = '0;
        last_d[tgt] = dmd_blk;
        next_d[tgt] = dmd_blk;
        ahd_d[tgt]  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (rst) begin
        st_q[i]   <= ST_FREE;
        last_q[i] <= '0;
        strd_q[i] <= '0;
        next_q[i] <= '0;
        ahd_q[i]  <= '0;
        age_q[i]  <= IW'(i);
      end else begin
        st_q[i]   <= st_d[i];
        last_q[i] <= last_d[i];
        strd_q[i] <= strd_d[i];
        next_q[i] <= next_d[i];
        ahd_q[i]  <= ahd_d[i];
        age_q[i]  <= age_d[i];
      end
    end
  end

endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import pf_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter int              NUM_STREAMS = 8,
  parameter int              LOOKAHEAD   = 12,
  parameter int              NEAR_WIN    = 16,
  parameter logic [ADDR_W-1:0] PF_LIMIT  = ADDR_W'(24'hF00000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmd_valid,
  input  logic [ADDR_W-1:0] dmd_blk,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_blk
);
  // Named internal events, visible to the bound checker.
  logic [NUM_STREAMS-1:0]        elig_vec;
  logic [NUM_STREAMS-1:0]        conf_vec;
  logic [NUM_STREAMS-1:0]        grant_vec;
  logic [NUM_STREAMS-1:0]        issue_vec;
  logic [NUM_STREAMS*ADDR_W-1:0] next_flat;
  logic                          any_req;
  logic                          slot_load;
  logic [ADDR_W-1:0]             cand_blk;

  pf_stream_table #(
    .NUM   (NUM_STREAMS),
    .AW    (ADDR_W),
    .LOOK  (LOOKAHEAD),
    .WIN   (NEAR_WIN),
    .LIMIT (PF_LIMIT)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .dmd_valid (dmd_valid),
    .dmd_blk   (dmd_blk),
    .issue_vec (issue_vec),
    .elig_vec  (elig_vec),
    .conf_vec  (conf_vec),
    .next_flat (next_flat)
  );

  pf_rr_arbiter #(.N(NUM_STREAMS)) u_arb (
    .clk   (clk),
    .rst   (rst),
    .req   (elig_vec),
    .adv   (slot_load),
    .grant (grant_vec),
    .any   (any_req)
  );

  always_comb begin
    cand_blk = '0;
    for (int i = 0; i < NUM_STREAMS; i++)
      if (grant_vec[i]) cand_blk = cand_blk | next_flat[i*ADDR_W +: ADDR_W];
  end

  assign issue_vec = grant_vec & {NUM_STREAMS{slot_load}};

  pf_issue_slot #(.AW(ADDR_W)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .cand_valid (any_req),
    .cand_blk   (cand_blk),
    .out_ready  (pf_ready),
    .load       (slot_load),
    .out_valid  (pf_valid),
    .out_blk    (pf_blk)
  );

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int          N     = 8,
  parameter int          AW    = 24,
  parameter logic [AW-1:0] LIMIT = '1
) (
  input logic          clk,
  input logic          rst,
  input logic          pf_valid,
  input logic          pf_ready,
  input logic [AW-1:0] pf_blk,
  input logic [N-1:0]  grant_vec,
  input logic [N-1:0]  conf_vec,
  input logic [N-1:0]  issue_vec
);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !pf_valid)
    else $error("reset leaves a prefetch presented");

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_blk))
    else $error("stalled prefetch changed or vanished");

  p_issue_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (|issue_vec) |=> pf_valid)
    else $error("issued prefetch not presented");

  p_limit_r11: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_blk < LIMIT)
    else $error("prefetch at or above limit");

  p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec))
    else $error("more than one stream granted");

  p_grant_conf_r3: assert property (@(posedge clk) disable iff (rst)
    (grant_vec & ~conf_vec) == '0)
    else $error("unconfirmed stream granted");

endmodule

bind stride_prefetcher pf_checker #(
  .N     (NUM_STREAMS),
  .AW    (ADDR_W),
  .LIMIT (PF_LIMIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pf_valid  (pf_valid),
  .pf_ready  (pf_ready),
  .pf_blk    (pf_blk),
  .grant_vec (grant_vec),
  .conf_vec  (conf_vec),
  .issue_vec (issue_vec)
);

// File: tb/tb_stride_prefetcher.sv
module tb_stride_prefetcher;
  localparam longint MASK  = 64'hFFFFFF;
  localparam longint LIMIT = 64'hF00000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dmd_valid = 1'b0;
  logic [23:0] dmd_blk = '0;
  logic        pf_ready = 1'b1;
  logic        pf_valid;
  logic [23:0] pf_blk;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  longint got[$];

  always #5 clk = ~clk;

  stride_prefetcher dut (
    .clk(clk), .rst(rst), .dmd_valid(dmd_valid), .dmd_blk(dmd_blk),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_blk(pf_blk)
  );

  // ---------------- behavioural reference model ----------------
  int     m_st[8];      // 0 free, 1 allocated, 2 one stride, 3 confirmed
  longint m_last[8], m_strd[8], m_nxt[8];
  int     m_ahd[8];
  int     lru[$];       // front = most recent
  bit     m_sv;
  longint m_sa;
  int     m_rr;

  function automatic bit m_elig(int i);
    return m_st[i] == 3 && m_ahd[i] < 12 && m_nxt[i] < LIMIT;
  endfunction

  task automatic m_touch(int i);
    int pos;
    pos = -1;
    for (int k = 0; k < lru.size(); k++) if (lru[k] == i) pos = k;
    if (pos >= 0) lru.delete(pos);
    lru.push_front(i);
  endtask

  task automatic m_reset();
    lru.delete();
    for (int i = 0; i < 8; i++) begin
      m_st[i] = 0; m_last[i] = 0; m_strd[i] = 0; m_nxt[i] = 0; m_ahd[i] = 0;
      lru.push_back(i);
    end
    m_sv = 0; m_sa = 0; m_rr = 0;
  endtask

  task automatic m_step();
    bit load; int win, tgt, kind; longint a, d;
    load = !m_sv || pf_ready;
    win = -1;
    for (int k = 0; k < 8; k++) begin
      int idx;
      idx = (m_rr + k) % 8;
      if (win < 0 && m_elig(idx)) win = idx;
    end
    if (load) begin
      if (win >= 0) begin
        m_sv = 1; m_sa = m_nxt[win];
        m_nxt[win] = (m_nxt[win] + m_strd[win]) & MASK;
        m_ahd[win]++;
        m_rr = (win + 1) % 8;
      end else m_sv = 0;
    end
    if (dmd_valid) begin
      a = longint'(dmd_blk); tgt = -1; kind = 0;
      for (int k = 0; k < 8; k++)
        if (tgt < 0 && m_st[k] >= 2 && ((m_last[k] + m_strd[k]) & MASK) == a) begin tgt = k; kind = 1; end
      for (int k = 0; k < 8; k++)
        if (tgt < 0 && m_st[k] != 0 && m_last[k] == a) begin tgt = k; kind = 2; end
      for (int k = 0; k < 8; k++) begin
        d = a - m_last[k];
        if (tgt < 0 && m_st[k] != 0 && d != 0 && d <= 16 && d >= -16) begin tgt = k; kind = 3; end
      end
      if (tgt < 0) begin
        kind = 4;
        for (int k = 0; k < 8; k++) if (tgt < 0 && m_st[k] == 0) tgt = k;
        if (tgt < 0) tgt = lru[lru.size() - 1];
      end
      case (kind)
        1: begin
          if (m_st[tgt] == 2) begin
            m_st[tgt] = 3; m_nxt[tgt] = (a + m_strd[tgt]) & MASK; m_ahd[tgt] = 0;
          end else if (m_ahd[tgt] > 0) m_ahd[tgt]--;
          else m_nxt[tgt] = (a + m_strd[tgt]) & MASK;
          m_last[tgt] = a;
        end
        3: begin
          m_st[tgt] = 2; m_strd[tgt] = (a - m_last[tgt]) & MASK; m_last[tgt] = a; m_ahd[tgt] = 0;
        end
        4: begin
          m_st[tgt] = 1; m_last[tgt] = a; m_strd[tgt] = 0; m_ahd[tgt] = 0; m_nxt[tgt] = a;
        end
        default: ;
      endcase
      m_touch(tgt);
    end
  endtask

  always @(posedge clk) begin
    if (rst) m_reset();
    else m_step();
  end

  // Accepted prefetches, recorded at the handshake edge.
  always @(posedge clk)
    if (!rst && pf_valid && pf_ready) got.push_back(longint'(pf_blk));

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Every cycle, away from the edge: outputs against the model.
  always @(negedge clk) begin
    if (!rst) begin
      chk(pf_valid === m_sv, cur_req, "pf_valid vs model", longint'(pf_valid), longint'(m_sv));
      if (m_sv)
        chk(longint'(pf_blk) === m_sa, cur_req, "pf_blk vs model", longint'(pf_blk), m_sa);
    end
  end

  task automatic demand(input logic [23:0] a);
    dmd_valid = 1'b1; dmd_blk = a;
    @(negedge clk);
    dmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_seq(input longint first, input longint stride, input int n, input string req);
    chk(got.size() == n, req, "prefetch count", longint'(got.size()), longint'(n));
    for (int k = 0; k < n && k < got.size(); k++)
      chk(got[k] == ((first + k * stride) & MASK), req, "prefetch block", got[k], (first + k * stride) & MASK);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired in %s actual=hung expected=done", cur_req);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    cur_req = "R1";
    chk(pf_valid == 1'b0, "R1", "valid after reset", longint'(pf_valid), 0);

    // R3 / R5: stride +4, confirm on third access, 12 ahead.
    cur_req = "R3"; got.delete();
    demand(24'h001000); demand(24'h001004); idle(5);
    chk(got.size() == 0, "R3", "no prefetch after two", longint'(got.size()), 0);
    demand(24'h001008); idle(30);
    check_seq(64'h100C, 4, 12, "R5");

    // R6: one more demand releases one more prefetch.
    cur_req = "R6"; got.delete();
    demand(24'h00100C); idle(6);
    check_seq(64'h103C, 4, 1, "R6");

    // R4: negative stride of three.
    cur_req = "R4"; got.delete();
    demand(24'h002000); demand(24'h001FFD); demand(24'h001FFA); idle(30);
    check_seq(64'h1FF7, -3, 12, "R4");

    // R7: break a +2 stream with a distance of 3.
    cur_req = "R7"; got.delete();
    demand(24'h003000); demand(24'h003002); demand(24'h003004); idle(30);
    got.delete();
    demand(24'h003007); idle(6);
    chk(got.size() == 0, "R7", "restrided stream idle", longint'(got.size()), 0);
    demand(24'h00300A); idle(30);
    check_seq(64'h300D, 3, 12, "R7");

    // R8: repeat of last block changes nothing.
    cur_req = "R8"; got.delete();
    demand(24'h00100C); idle(6);
    chk(got.size() == 0, "R8", "repeat issues nothing", longint'(got.size()), 0);
    demand(24'h001010); idle(6);
    check_seq(64'h1040, 4, 1, "R8");

    // R10: stall with ready low.
    cur_req = "R10"; pf_ready = 1'b0; got.delete();
    demand(24'h004000); demand(24'h004001); demand(24'h004002); idle(3);
    chk(pf_valid == 1'b1, "R10", "valid while stalled", longint'(pf_valid), 1);
    chk(pf_blk == 24'h004003, "R10", "block while stalled", longint'(pf_blk), 64'h4003);
    idle(10);
    chk(pf_valid == 1'b1 && pf_blk == 24'h004003, "R10", "held block", longint'(pf_blk), 64'h4003);
    pf_ready = 1'b1; idle(30);
    check_seq(64'h4003, 1, 12, "R10");

    // R9: two streams waiting, served alternately.
    cur_req = "R9"; pf_ready = 1'b0; got.delete();
    demand(24'h005000); demand(24'h005001); demand(24'h005002);
    demand(24'h006000); demand(24'h006001); demand(24'h006002); idle(3);
    pf_ready = 1'b1; idle(40);
    chk(got.size() == 24, "R9", "total from two streams", longint'(got.size()), 24);
    for (int k = 0; k < 12 && 2 * k + 1 < got.size(); k++) begin
      chk(got[2*k]   == 64'h5003 + k, "R9", "turn of first stream",  got[2*k],   64'h5003 + k);
      chk(got[2*k+1] == 64'h6003 + k, "R9", "turn of second stream", got[2*k+1], 64'h6003 + k);
    end

    // R11: limit reached upward, and a wrapped downward stream.
    cur_req = "R11"; got.delete();
    demand(24'hEFFFD0); demand(24'hEFFFD8); demand(24'hEFFFE0); idle(30);
    check_seq(64'hEFFFE8, 8, 3, "R11");
    got.delete();
    demand(24'h000010); demand(24'h000008); demand(24'h000000); idle(20);
    chk(got.size() == 0, "R11", "wrapped stream silent", longint'(got.size()), 0);

    // R2: full table evicts the least recent stream.
    cur_req = "R2"; got.delete();
    demand(24'h007000); demand(24'h001FF7); idle(10);
    chk(got.size() == 0, "R2", "evicted stream forgotten", longint'(got.size()), 0);

    // R12: accesses beyond the window do not train.
    cur_req = "R12";
    demand(24'h007020); demand(24'h007040); idle(10);
    chk(got.size() == 0, "R12", "far accesses separate", longint'(got.size()), 0);

    cur_req = "R2"; got.delete();
    demand(24'h008000); demand(24'h008001); demand(24'h008002); idle(6);
    chk(got.size() > 0, "R2", "fresh stream after eviction", longint'(got.size()), 1);
    if (got.size() > 0)
      chk(got[0] == 64'h8003, "R2", "first block of fresh stream", got[0], 64'h8003);
    idle(20);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule